// File: doc/BRIEF.md
# I2C Master Serial Clock Rate Generator

This block derives the serial clock timing of an I2C master from the system clock. Two configuration fields set the rate: an 8-bit modulus and a bypass bit. The bypass bit removes a fixed divide-by-eight prescaler from the path. The prescaler output steps a modulus counter. Each time the counter wraps, the serial clock line toggles. A complete serial clock period is therefore `2 * (modulus + 1)` system clocks, multiplied by 8 when the prescaler is in use. Settings run from 6 system clocks (modulus 2, bypassed) up to 4096 system clocks (modulus 255, prescaled).

The block drives three outputs:
- a square serial clock drive;
- a one-cycle divided-clock enable at every phase change;
- a one-cycle tick in the middle of every low phase, which a data shift engine can use to move SDA while SCL is low.

A configuration write is first kept in a holding register. It moves into the working register only at the next falling edge of the serial clock, so a change never cuts a phase short. While the block is disabled it holds its counters cleared and releases the clock line high.

The line as actually seen on the bus runs about three system clocks longer than the programmed period, plus the pad delay and the rise time. Software must allow for this when it picks a setting.

Top module: `sclRateGen`

## Requirements
- R1: While enabled, each high phase and each low phase of `sclOut` lasts H = (modulus + 1) * P system clocks. P is 1 when the bypass bit is 1 and 8 when it is 0. A full period is 2H.
- R2: `sclOut` changes level only on a modulus-counter wrap. `divTick` is high for exactly the first cycle of each new phase (the cycle in which `sclOut` first shows its new level) and is low otherwise.
- R3: A write with bypass = 1 and modulus 0 or 1 stores modulus 2 and sets `cfgError`. `cfgError` stays set until reset. With bypass = 0, modulus values 0 and 1 are stored unchanged and do not set `cfgError`.
- R4: The settings at the ends of the range give a 6-clock period (modulus 2, bypass 1) and a 4096-clock period (modulus 255, bypass 0).
- R5: A configuration written while the clock runs takes effect from the next falling edge of `sclOut`. The phase in progress and the high phase after it keep the old setting. A configuration written while disabled, at least one cycle before `enable` rises, governs the first period.
- R6: While `enable` is low, `sclOut` is 1 and `divTick` and `midTick` are 0 from the next cycle on. After `enable` rises, `sclOut` falls after exactly H clock edges, counting the first edge at which `enable` is sampled high.
- R7: `midTick` pulses once per low phase, in cycle floor(H/2) of that phase, where cycle 0 is the first low cycle. It never pulses during a high phase and never together with `divTick`.
- R8: After reset, `sclOut` = 1, `divTick` = 0, `midTick` = 0 and `cfgError` = 0. The stored configuration is modulus 255 with bypass 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the generator; when low, counters are cleared and SCL is released high |
| cfgWrite | input | 1 | Load `cfgModulus` and `cfgBypass` into the holding register |
| cfgModulus | input | 8 | Divider modulus; each phase lasts modulus + 1 prescaled ticks |
| cfgBypass | input | 1 | 1 removes the divide-by-eight prescaler |
| sclOut | output | 1 | Square serial clock drive, idle high |
| divTick | output | 1 | One-cycle pulse at the start of every SCL phase |
| midTick | output | 1 | One-cycle pulse in the middle of every SCL low phase |
| cfgError | output | 1 | Sticky flag: an illegal bypassed modulus was written and clamped |

## Verification
The bench runs seven settings, measuring the first delay after enable, the low length, the high length and the position of the mid-phase tick for each:
- Bypassed moduli 2, 3, 9 and 255 give odd and even phase lengths. They tell a correct floor(H/2) mid-tick position apart from an off-by-one one, and show that the modulus counter compares against its full width.
- Prescaled moduli 0, 1 and 5 separate a working divide-by-eight from a missing or miscounted prescaler, because every length must be a multiple of eight.
- The 4096-clock extreme checks the largest count.

Directed runs then cover the remaining cases:
- a mid-period rewrite, which shows whether the update waits for the falling edge;
- clamped writes in both bypass settings, which show whether the error flag is sticky and whether the clamp applies only when the prescaler is bypassed;
- a disable while running, which shows the line being released.

// File: rtl/sclGenPkg.sv
package sclGenPkg;

  // Strobes passed from the control half to the datapath each cycle.
  typedef struct packed {
    logic clear;     // hold counters and line in their idle state
    logic presTick;  // one prescaled tick this cycle
  } ctrlStrobes_t;

endpackage

// File: rtl/sclGenCtrl.sv
module sclGenCtrl
  import sclGenPkg::*;
#(
  parameter int MOD_W     = 8,
  parameter int PRE_DIV   = 8,
  parameter int MIN_MOD   = 2,
  parameter int RESET_MOD = 255,
  parameter bit RESET_BYP = 1'b0,
  localparam int PRE_W    = $clog2(PRE_DIV)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             cfgWrite,
  input  logic [MOD_W-1:0] cfgModulus,
  input  logic             cfgBypass,
  input  logic             periodStart,
  output ctrlStrobes_t     strobes,
  output logic [MOD_W-1:0] activeMod,
  output logic             activeByp,
  output logic [PRE_W-1:0] presCnt,
  output logic             cfgError
);

  localparam logic [MOD_W-1:0] MIN_MOD_V   = MOD_W'(MIN_MOD);
  localparam logic [MOD_W-1:0] RESET_MOD_V = MOD_W'(RESET_MOD);
  localparam logic [PRE_W-1:0] PRE_LAST    = PRE_W'(PRE_DIV - 1);

  logic [MOD_W-1:0] holdMod;
  logic             holdByp;
  logic             illegalWrite;
  logic             loadActive;

  // A bypassed modulus below the minimum would give a period under the legal floor.
  assign illegalWrite = cfgWrite && cfgBypass && (cfgModulus < MIN_MOD_V);

  // Holding register: software view, clamped on entry.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdMod  <= RESET_MOD_V;
      holdByp  <= RESET_BYP;
      cfgError <= 1'b0;
    end else if (cfgWrite) begin
      holdByp <= cfgBypass;
      if (illegalWrite) begin
        holdMod  <= MIN_MOD_V;
        cfgError <= 1'b1;
      end else begin
        holdMod <= cfgModulus;
      end
    end
  end

  // Working register: follows the holding register while idle, else only at a period start.
  assign loadActive = !enable || periodStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeMod <= RESET_MOD_V;
      activeByp <= RESET_BYP;
    end else if (loadActive) begin
      activeMod <= holdMod;
      activeByp <= holdByp;
    end
  end

  // Fixed prescaler; parked at zero when idle or bypassed.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presCnt <= '0;
    end else if (!enable || activeByp) begin
      presCnt <= '0;
    end else begin
      presCnt <= presCnt + PRE_W'(1);
    end
  end

  always_comb begin
    strobes.clear    = !enable;
    strobes.presTick = enable && (activeByp || (presCnt == PRE_LAST));
  end

endmodule

// File: rtl/sclGenDatapath.sv
module sclGenDatapath
  import sclGenPkg::*;
#(
  parameter int MOD_W   = 8,
  parameter int PRE_DIV = 8,
  localparam int PRE_W  = $clog2(PRE_DIV),
  localparam int EL_W   = MOD_W + PRE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [MOD_W-1:0] activeMod,
  input  logic             activeByp,
  input  logic [PRE_W-1:0] presCnt,
  output logic             periodStart,
  output logic             sclOut,
  output logic             divTick,
  output logic             midTick
);

  logic [MOD_W-1:0] modCnt;
  logic             wrap;
  logic [MOD_W:0]   ratio;
  logic [EL_W-1:0]  elapsed;
  logic [EL_W-1:0]  midTarget;
  logic             midHit;

  assign wrap        = strobes.presTick && (modCnt == activeMod);
  assign periodStart = wrap && sclOut;   // a falling edge starts a new period

  // Cycles elapsed in the current phase and the mid-point of the phase.
  assign ratio = {1'b0, activeMod} + {{MOD_W{1'b0}}, 1'b1};

  generate
    if (PRE_W > 1) begin : g_prescaledMid
      always_comb begin
        elapsed   = activeByp ? EL_W'(modCnt) : {modCnt, presCnt};
        midTarget = activeByp ? (EL_W'(ratio >> 1) - EL_W'(1))
                              : ((EL_W'(ratio) << (PRE_W - 1)) - EL_W'(1));
      end
    end else begin : g_shortMid
      always_comb begin
        elapsed   = activeByp ? EL_W'(modCnt) : {modCnt, presCnt};
        midTarget = activeByp ? (EL_W'(ratio >> 1) - EL_W'(1))
                              : (EL_W'(ratio) - EL_W'(1));
      end
    end
  endgenerate

  assign midHit = !sclOut && (elapsed == midTarget);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modCnt  <= '0;
      sclOut  <= 1'b1;
      divTick <= 1'b0;
      midTick <= 1'b0;
    end else if (strobes.clear) begin
      modCnt  <= '0;
      sclOut  <= 1'b1;
      divTick <= 1'b0;
      midTick <= 1'b0;
    end else begin
      divTick <= wrap;
      midTick <= midHit;
      if (strobes.presTick) begin
        if (wrap) begin
          modCnt <= '0;
          sclOut <= !sclOut;
        end else begin
          modCnt <= modCnt + MOD_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/sclRateGen.sv
module sclRateGen
  import sclGenPkg::*;
#(
  parameter int MOD_W     = 8,
  parameter int PRE_DIV   = 8,
  parameter int MIN_MOD   = 2,
  parameter int RESET_MOD = 255,
  parameter bit RESET_BYP = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             cfgWrite,
  input  logic [MOD_W-1:0] cfgModulus,
  input  logic             cfgBypass,
  output logic             sclOut,
  output logic             divTick,
  output logic             midTick,
  output logic             cfgError
);

  localparam int PRE_W = $clog2(PRE_DIV);

  ctrlStrobes_t     strobes;
  logic [MOD_W-1:0] activeMod;
  logic             activeByp;
  logic [PRE_W-1:0] presCnt;
  logic             periodStart;

  sclGenCtrl #(
    .MOD_W(MOD_W), .PRE_DIV(PRE_DIV), .MIN_MOD(MIN_MOD),
    .RESET_MOD(RESET_MOD), .RESET_BYP(RESET_BYP)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable),
    .cfgWrite(cfgWrite), .cfgModulus(cfgModulus), .cfgBypass(cfgBypass),
    .periodStart(periodStart), .strobes(strobes),
    .activeMod(activeMod), .activeByp(activeByp),
    .presCnt(presCnt), .cfgError(cfgError)
  );

  sclGenDatapath #(
    .MOD_W(MOD_W), .PRE_DIV(PRE_DIV)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .activeMod(activeMod), .activeByp(activeByp), .presCnt(presCnt),
    .periodStart(periodStart), .sclOut(sclOut),
    .divTick(divTick), .midTick(midTick)
  );

endmodule

// File: rtl/sclGenChecker.sv
module sclGenChecker (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic sclOut,
  input logic divTick,
  input logic midTick,
  input logic cfgError
);

  // R2: a level change on the line while running comes with the phase strobe
  assert_scl_toggle_on_tick_R2: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && (sclOut != $past(sclOut))) |-> divTick);

  // R7: mid tick only inside a low phase
  assert_mid_in_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    midTick |-> !sclOut);

  // R7: mid tick and phase strobe never coincide
  assert_ticks_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(midTick && divTick));

  // R3: the error flag is sticky
  assert_error_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |=> cfgError);

  // R6: idle releases the line and silences both ticks
  assert_idle_released_R6: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (sclOut && !divTick && !midTick));

endmodule

bind sclRateGen sclGenChecker i_sclGenChecker (
  .clk(clk), .rstN(rstN), .enable(enable), .sclOut(sclOut),
  .divTick(divTick), .midTick(midTick), .cfgError(cfgError)
);

// File: tb/test_sclRateGen.sv
`timescale 1ns/1ps
module test_sclRateGen;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       cfgWrite = 1'b0;
  logic [7:0] cfgModulus = '0;
  logic       cfgBypass = 1'b0;
  logic       sclOut, divTick, midTick, cfgError;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  sclRateGen i_sclRateGen (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgWrite(cfgWrite),
    .cfgModulus(cfgModulus), .cfgBypass(cfgBypass),
    .sclOut(sclOut), .divTick(divTick), .midTick(midTick), .cfgError(cfgError)
  );

  // {modulus, bypass, expected half period in clocks}
  localparam int NVEC = 7;
  localparam int VEC [NVEC][3] = '{
    '{2,   1, 3},
    '{3,   1, 4},
    '{9,   1, 10},
    '{0,   0, 8},
    '{1,   0, 16},
    '{5,   0, 48},
    '{255, 1, 256}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic writeCfg(input int m, input bit b);
    @(negedge clk);
    cfgWrite = 1'b1; cfgModulus = 8'(m); cfgBypass = b;
    @(negedge clk);
    cfgWrite = 1'b0;
  endtask

  // Length of the phase in progress, from the current sample; ends on the first sample of the next phase.
  task automatic phaseLen(output int len, output int midAt, output int midCount);
    logic lvl;
    lvl = sclOut; len = 1; midAt = -1; midCount = 0;
    for (int i = 0; i < 10000; i++) begin
      @(negedge clk);
      if (sclOut != lvl) break;
      if (midTick) begin midCount++; midAt = len; end
      len++;
    end
  endtask

  // Configure while idle, enable, measure first delay, low and high phases.
  task automatic runSetting(input int m, input bit b, input int expH, input string req);
    int n, lowLen, highLen, midAt, midCount, hAt, hCnt;
    @(negedge clk); enable = 1'b0;
    writeCfg(m, b);
    @(negedge clk); @(negedge clk);
    enable = 1'b1;
    n = 0;
    for (int i = 0; i < 10000; i++) begin
      @(negedge clk); n++;
      if (!sclOut) break;
    end
    check(n == expH, "R6", $sformatf("first fall delay m=%0d b=%0d", m, b), n, expH);
    check(divTick == 1'b1, "R2", "divTick at start of low", int'(divTick), 1);
    phaseLen(lowLen, midAt, midCount);
    check(lowLen == expH, req, $sformatf("low length m=%0d b=%0d", m, b), lowLen, expH);
    check(midCount == 1 && midAt == expH / 2, "R7", "mid tick position", midAt, expH / 2);
    check(divTick == 1'b1, "R2", "divTick at start of high", int'(divTick), 1);
    phaseLen(highLen, hAt, hCnt);
    check(highLen == expH, req, $sformatf("high length m=%0d b=%0d", m, b), highLen, expH);
    check(hCnt == 0, "R7", "no mid tick in high phase", hCnt, 0);
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        testsFailed++; testsRun++;
        $display("FAIL watchdog: actual %0d expected < 150000 cycles", cycles);
        $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
        $finish;
      end
    end
  end

  initial begin : stim
    int l1, l2, l3, l4, ma, mc;
    int bad;
    repeat (3) @(negedge clk);
    // R8: reset state
    check(sclOut == 1'b1, "R8", "sclOut in reset", int'(sclOut), 1);
    rstN = 1'b1;
    @(negedge clk);
    check(sclOut == 1'b1 && !divTick && !midTick, "R8", "outputs after reset",
          int'({sclOut, divTick, midTick}), 4);
    check(cfgError == 1'b0, "R8", "cfgError after reset", int'(cfgError), 0);
    // R8: stored reset setting is modulus 255 prescaled (H = 2048)
    enable = 1'b1;
    l1 = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk); l1++;
      if (!sclOut) break;
    end
    check(l1 == 2048, "R8", "default setting first fall", l1, 2048);

    // R1: table walk
    for (int v = 0; v < NVEC; v++)
      runSetting(VEC[v][0], VEC[v][1] != 0, VEC[v][2], "R1");
    check(cfgError == 1'b0, "R3", "no error for prescaled modulus 0/1", int'(cfgError), 0);

    // R4: range extremes
    runSetting(2, 1'b1, 3, "R4");
    runSetting(255, 1'b0, 2048, "R4");

    // R5: rewrite during a running period
    runSetting(2, 1'b1, 3, "R5");
    // now in cycle 0 of a low phase with modulus 2
    cfgWrite = 1'b1; cfgModulus = 8'd5; cfgBypass = 1'b1;
    fork begin @(negedge clk); cfgWrite = 1'b0; end join_none
    phaseLen(l1, ma, mc);
    phaseLen(l2, ma, mc);
    phaseLen(l3, ma, mc);
    phaseLen(l4, ma, mc);
    check(l1 == 3, "R5", "current low keeps old setting", l1, 3);
    check(l2 == 3, "R5", "following high keeps old setting", l2, 3);
    check(l3 == 6, "R5", "next low uses new setting", l3, 6);
    check(l4 == 6, "R5", "next high uses new setting", l4, 6);

    // R6: disable while running
    @(negedge clk); enable = 1'b0;
    @(negedge clk);
    check(sclOut == 1'b1, "R6", "line released after disable", int'(sclOut), 1);
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!sclOut || divTick || midTick) bad++;
    end
    check(bad == 0, "R6", "idle cycles with activity", bad, 0);

    // R3: clamp of bypassed modulus 0 and 1
    writeCfg(0, 1'b1);
    check(cfgError == 1'b1, "R3", "error after bypassed modulus 0", int'(cfgError), 1);
    runSetting(0, 1'b1, 3, "R3");
    runSetting(4, 1'b1, 5, "R1");
    check(cfgError == 1'b1, "R3", "error sticky after legal write", int'(cfgError), 1);
    @(negedge clk); rstN = 1'b0; enable = 1'b0;
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check(cfgError == 1'b0, "R3", "error cleared by reset", int'(cfgError), 0);
    runSetting(1, 1'b1, 3, "R3");
    check(cfgError == 1'b1, "R3", "error after bypassed modulus 1", int'(cfgError), 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule